// File: doc/BRIEF.md
# Carrier Detect and Gain Select Logic

This block sits behind the receive level comparator of a voiceband FSK modem. It takes three level flags, which have already been compared against fixed thresholds in the analog domain, and turns them into two outputs. The first is a carrier-detect flag. The second is a two-level gain choice for the programmable input amplifier.

The flags are sampled only when the `tick` strobe is high. Each flag feeds its own saturating up/down counter, and that counter acts as an in-band energy integrator. An output is changed only when an integrator has held a qualifying level for a run of consecutive sample ticks. This run-length delay keeps short dropouts and noise bursts from toggling carrier detect or the amplifier gain.

Carrier detect uses separate rise and fall runs, and the fall run is the longer of the two. The gain selection has hysteresis. It switches to high gain only on a weak-signal indication and to low gain only on a strong-signal indication. Between those two levels it keeps its current setting. Automatic gain control can be frozen with `agc_en`.

Top module: `cd_agc_level`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `carrier_det` is 0 and `gain_hi` is 1. All integrators and run counters start at 0.
- R2: Each of the three integrators is a CNT_W-bit saturating counter that changes only on a tick. It counts up by 1 if its flag is 1, and down by 1 if its flag is 0. It stops at 2^CNT_W-1 and at 0.
- R3: While `carrier_det` is 0, a tick qualifies if the carrier integrator holds a value >= C_UP_TH before that tick's update. On the CD_ON_DLY-th consecutive qualifying tick, `carrier_det` becomes 1, visible after that clock edge.
- R4: Any tick that does not qualify clears the run count for carrier detect. A dropout shorter than the fall run therefore leaves `carrier_det` unchanged.
- R5: While `carrier_det` is 1, a tick qualifies if the carrier integrator holds a value <= C_DN_TH before the update. On the CD_OFF_DLY-th consecutive qualifying tick, `carrier_det` becomes 0.
- R6: When `gain_hi` is 0 and `agc_en` is 1, a tick qualifies if the weak integrator is >= G_TH and the strong integrator is < G_TH. On the G_DLY-th consecutive qualifying tick, `gain_hi` becomes 1 (20 dB).
- R7: When `gain_hi` is 1 and `agc_en` is 1, a tick qualifies if the strong integrator is >= G_TH. On the G_DLY-th consecutive qualifying tick, `gain_hi` becomes 0 (6 dB).
- R8: If neither gain condition holds, `gain_hi` keeps its value and the gain run count clears.
- R9: While `agc_en` is 0, `gain_hi` does not change and the gain run count is held at 0. The integrators keep running.
- R10: On clock edges where `tick` is 0, neither output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe; all state advances only when high |
| car_flag | input | 1 | Level above carrier threshold (about -48 dBm) |
| weak_flag | input | 1 | Level below lower gain threshold (about -27 dBm) |
| strong_flag | input | 1 | Level above upper gain threshold (about -23 dBm) |
| agc_en | input | 1 | 1 = automatic gain control active, 0 = gain frozen |
| carrier_det | output | 1 | Carrier detect flag |
| gain_hi | output | 1 | 1 = high gain (20 dB), 0 = low gain (6 dB) |

## Verification
The assertions check every cycle that the outputs and integrators move only on ticks and that the gain is frozen while `agc_en` is low. They also check that each output transition was preceded by the matching integrator condition (carrier above or below its threshold, weak or strong level). Run lengths cannot be seen in single cycles. The exact tick on which an output flips, the clearing of a run by a dropout and the hysteresis band are shown by the bench: directed runs with worked-out tick counts, and a long random phase compared against a tick-level model of the requirements.

// File: rtl/cd_agc_level.sv
module cd_agc_level #(
  parameter int CNT_W      = 6,
  parameter int C_UP_TH    = 40,
  parameter int C_DN_TH    = 16,
  parameter int CD_ON_DLY  = 8,
  parameter int CD_OFF_DLY = 24,
  parameter int G_TH       = 40,
  parameter int G_DLY      = 4,
  parameter int DLY_W      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic car_flag,
  input  logic weak_flag,
  input  logic strong_flag,
  input  logic agc_en,
  output logic carrier_det,
  output logic gain_hi
);
  localparam logic [CNT_W-1:0] LVL_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] C_UP_V  = CNT_W'(C_UP_TH);
  localparam logic [CNT_W-1:0] C_DN_V  = CNT_W'(C_DN_TH);
  localparam logic [CNT_W-1:0] G_V     = CNT_W'(G_TH);
  localparam logic [DLY_W-1:0] ON_LAST  = DLY_W'(CD_ON_DLY - 1);
  localparam logic [DLY_W-1:0] OFF_LAST = DLY_W'(CD_OFF_DLY - 1);
  localparam logic [DLY_W-1:0] G_LAST   = DLY_W'(G_DLY - 1);

  logic [2:0]       flg;
  logic [CNT_W-1:0] lvl [3];

  assign flg = {strong_flag, weak_flag, car_flag};

  for (genvar gi = 0; gi < 3; gi++) begin : g_int
    always_ff @(posedge clk) begin
      if (!rst_n)
        lvl[gi] <= '0;
      else if (tick) begin
        if (flg[gi] && lvl[gi] != LVL_MAX)
          lvl[gi] <= lvl[gi] + 1'b1;
        else if (!flg[gi] && lvl[gi] != '0)
          lvl[gi] <= lvl[gi] - 1'b1;
      end
    end
  end

  logic [DLY_W-1:0] cd_cnt, g_cnt;
  logic             cd_cond, g_cond, weak_ind, strong_ind;
  logic [DLY_W-1:0] cd_last;

  assign cd_cond    = carrier_det ? (lvl[0] <= C_DN_V) : (lvl[0] >= C_UP_V);
  assign cd_last    = carrier_det ? OFF_LAST : ON_LAST;
  assign weak_ind   = lvl[1] >= G_V;
  assign strong_ind = lvl[2] >= G_V;
  assign g_cond     = gain_hi ? strong_ind : (weak_ind && !strong_ind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carrier_det <= 1'b0;
      cd_cnt      <= '0;
    end else if (tick) begin
      if (!cd_cond)
        cd_cnt <= '0;
      else if (cd_cnt == cd_last) begin
        cd_cnt      <= '0;
        carrier_det <= !carrier_det;
      end else
        cd_cnt <= cd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_hi <= 1'b1;
      g_cnt   <= '0;
    end else if (tick) begin
      if (!agc_en || !g_cond)
        g_cnt <= '0;
      else if (g_cnt == G_LAST) begin
        g_cnt   <= '0;
        gain_hi <= !gain_hi;
      end else
        g_cnt <= g_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cd_agc_level_chk.sv
module cd_agc_level_chk #(
  parameter int CNT_W   = 6,
  parameter int C_UP_TH = 40,
  parameter int C_DN_TH = 16,
  parameter int G_TH    = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             agc_en,
  input logic             carrier_det,
  input logic             gain_hi,
  input logic [CNT_W-1:0] car_lvl,
  input logic [CNT_W-1:0] weak_lvl,
  input logic [CNT_W-1:0] strong_lvl
);
  localparam logic [CNT_W-1:0] C_UP_V = CNT_W'(C_UP_TH);
  localparam logic [CNT_W-1:0] C_DN_V = CNT_W'(C_DN_TH);
  localparam logic [CNT_W-1:0] G_V    = CNT_W'(G_TH);

  p_int_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(car_lvl) && $stable(weak_lvl) && $stable(strong_lvl));

  p_cd_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_det) |-> $past(car_lvl) >= C_UP_V);

  p_cd_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier_det) |-> $past(car_lvl) <= C_DN_V);

  p_gain_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gain_hi) |-> ($past(weak_lvl) >= G_V) && ($past(strong_lvl) < G_V));

  p_gain_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gain_hi) |-> $past(strong_lvl) >= G_V);

  p_gain_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !agc_en |=> $stable(gain_hi));

  p_out_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(carrier_det) && $stable(gain_hi));
endmodule

bind cd_agc_level cd_agc_level_chk #(
  .CNT_W(CNT_W), .C_UP_TH(C_UP_TH), .C_DN_TH(C_DN_TH), .G_TH(G_TH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .agc_en(agc_en),
  .carrier_det(carrier_det), .gain_hi(gain_hi),
  .car_lvl(lvl[0]), .weak_lvl(lvl[1]), .strong_lvl(lvl[2])
);

// File: tb/test_cd_agc_level.sv
module test_cd_agc_level;
  localparam int CW = 6, CUP = 40, CDN = 16, ON_D = 8, OFF_D = 24, GT = 40, GD = 4;
  localparam int LMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick, car_flag, weak_flag, strong_flag, agc_en;
  logic carrier_det, gain_hi;

  cd_agc_level #(.CNT_W(CW), .C_UP_TH(CUP), .C_DN_TH(CDN), .CD_ON_DLY(ON_D),
    .CD_OFF_DLY(OFF_D), .G_TH(GT), .G_DLY(GD), .DLY_W(8)) i_cd_agc_level (
    .clk(clk), .rst_n(rst_n), .tick(tick), .car_flag(car_flag),
    .weak_flag(weak_flag), .strong_flag(strong_flag), .agc_en(agc_en),
    .carrier_det(carrier_det), .gain_hi(gain_hi));

  int checks = 0, errors = 0;
  int m_lvl [3];
  int m_cd, m_g, m_cdc, m_gc;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) m_lvl[i] = 0;
    m_cd = 0; m_g = 1; m_cdc = 0; m_gc = 0;
  endtask

  task automatic model_step();
    int f[3];
    bit cdq, gq, wi, si;
    f[0] = car_flag; f[1] = weak_flag; f[2] = strong_flag;
    cdq = m_cd ? (m_lvl[0] <= CDN) : (m_lvl[0] >= CUP);
    wi = m_lvl[1] >= GT;
    si = m_lvl[2] >= GT;
    gq = m_g ? si : (wi && !si);
    if (!cdq) m_cdc = 0;
    else if (m_cdc == (m_cd ? OFF_D : ON_D) - 1) begin m_cdc = 0; m_cd = !m_cd; end
    else m_cdc++;
    if (!agc_en || !gq) m_gc = 0;
    else if (m_gc == GD - 1) begin m_gc = 0; m_g = !m_g; end
    else m_gc++;
    for (int i = 0; i < 3; i++) begin
      if (f[i] != 0 && m_lvl[i] < LMAX) m_lvl[i]++;
      else if (f[i] == 0 && m_lvl[i] > 0) m_lvl[i]--;
    end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      if (rst_n && tick) model_step();
      @(negedge clk);
      chk("R3 R4 R5 carrier_det model", carrier_det, m_cd);
      chk("R6 R7 R8 R9 gain_hi model", gain_hi, m_g);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; car_flag = 1'b0; weak_flag = 1'b0;
    strong_flag = 1'b0; agc_en = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 carrier_det reset", carrier_det, 0);
    chk("R1 gain_hi reset", gain_hi, 1);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pc, pw, ps;
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();

    tick = 1'b1; car_flag = 1'b1;
    cyc(47);
    chk("R3 carrier_det before run done", carrier_det, 0);
    cyc(1);
    chk("R3 carrier_det after run", carrier_det, 1);
    tick = 1'b0; car_flag = 1'b0;
    cyc(20);
    chk("R10 carrier_det held without tick", carrier_det, 1);
    tick = 1'b1; car_flag = 1'b1;
    cyc(30);
    car_flag = 1'b0;
    cyc(55);
    car_flag = 1'b1;
    cyc(40);
    chk("R4 carrier_det survives dropout", carrier_det, 1);
    car_flag = 1'b0;
    cyc(55);
    chk("R5 carrier_det before fall run done", carrier_det, 1);
    cyc(1);
    chk("R5 carrier_det after fall run", carrier_det, 0);

    do_reset();
    tick = 1'b1; strong_flag = 1'b1;
    cyc(43);
    chk("R7 gain_hi before run done", gain_hi, 1);
    cyc(1);
    chk("R7 gain_hi low after strong run", gain_hi, 0);
    agc_en = 1'b0; strong_flag = 1'b0; weak_flag = 1'b1;
    cyc(100);
    chk("R9 gain_hi frozen while disabled", gain_hi, 0);
    agc_en = 1'b1;
    cyc(3);
    chk("R6 gain_hi before run done", gain_hi, 0);
    cyc(1);
    chk("R6 gain_hi high after weak run", gain_hi, 1);
    weak_flag = 1'b0;
    cyc(100);
    chk("R8 gain_hi held between thresholds", gain_hi, 1);
    tick = 1'b0; strong_flag = 1'b1;
    cyc(80);
    chk("R10 gain_hi held without tick", gain_hi, 1);

    pc = 50; pw = 50; ps = 50;
    for (int c = 0; c < 6000; c++) begin
      if (c % 60 == 0) begin
        pc = $urandom_range(0, 100);
        pw = $urandom_range(0, 100);
        ps = $urandom_range(0, 100);
        agc_en = ($urandom_range(0, 9) != 0);
      end
      tick        = ($urandom_range(0, 3) != 0);
      car_flag    = ($urandom_range(0, 99) < pc);
      weak_flag   = ($urandom_range(0, 99) < pw);
      strong_flag = ($urandom_range(0, 99) < ps);
      cyc(1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule